// File: doc/BRIEF.md
# Interleaved Bitstream Header Parser

This block sits on a byte stream, with a valid/ready handshake, that carries several configuration images woven together in fixed-size chunks. The images take turns, one chunk each. The block keeps only the bytes of one chosen image and throws the rest away. It checks that the chosen image opens with a fixed 13-byte signature. It then steps over the tagged header sections until it reaches the payload section, and it latches the payload length. Finally it passes the payload bytes downstream, subject to backpressure.

The controlling logic selects an image (counted from one) and states how many images are woven into the stream. It then pulses `start` and feeds the stream. The results appear on four outputs:
- `hdr_ok` reports a good signature.
- `parse_err` reports any failure.
- `payload_len` with `len_valid` gives the payload size.
- `done` pulses once the whole payload has left the block.

A new `start` pulse is needed before every parse.

Top module: `ilv_bitstream_parser`

## Requirements
- R1: After reset, and until `start` is pulsed, `in_ready`, `out_valid`, `hdr_ok`, `parse_err`, `len_valid` and `done` are all 0. An input byte offered during the `start` cycle is not accepted.
- R2: Counting accepted bytes from 0 since the last `start`, byte g belongs to the selected image when floor(g / CHUNK_BYTES) mod `img_count` equals `img_sel` - 1 (CHUNK_BYTES defaults to 288). Bytes of other images are accepted whenever the block is still parsing, even while `out_ready` is low, and they never reach `out_valid`.
- R3: The first 13 selected bytes must be 00 09 0F F0 0F F0 0F F0 0F F0 00 00 01. On the first mismatch, `parse_err` rises in the cycle after that byte is accepted. `hdr_ok` stays 0 and no further byte is accepted.
- R4: `hdr_ok` goes to 1 in the cycle after the 13th matching signature byte. It stays 1 until the next `start`.
- R5: After the signature, each section is a tag byte followed by a big-endian length and then the content. Tags 0x61..0x64 carry a 2-byte length and their content is skipped. Tag 0x65 carries a 4-byte length, which is latched on `payload_len`, and `len_valid` then rises.
- R6: A tag byte outside 0x61..0x65 sets `parse_err` in the cycle after it is accepted.
- R7: A 2-byte section length greater than SHORT_MAX (default 255) sets `parse_err` in the cycle after its last length byte is accepted.
- R8: Header bytes after the signature are counted: tags, length bytes of tags 0x61..0x64, and skipped content. Once SEARCH_LIMIT (default 100) of them are consumed before the 0x65 tag is read, the walk stops. `parse_err` rises with exactly 13 + SEARCH_LIMIT selected bytes consumed.
- R9: During the payload, `out_valid` is high exactly when a selected byte is offered, and `out_data` equals `in_data`. A selected byte is accepted only while `out_ready` is high, and the bytes leave in stream order.
- R10: `done` is a one-cycle pulse. It rises in the cycle after the last payload byte is handed over, or after the last length byte when the payload length is 0. It never coincides with `parse_err`, and no byte is accepted afterwards.
- R11: `start` clears `hdr_ok`, `parse_err`, `len_valid`, the byte index and the section state, including in the middle of a parse or after an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle pulse that begins a new parse |
| img_sel | input | IMG_W | Selected image, counted from 1 |
| img_count | input | IMG_W | Number of interleaved images |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte |
| in_ready | output | 1 | Input byte accepted when high together with in_valid |
| out_valid | output | 1 | Payload byte valid |
| out_data | output | 8 | Payload byte |
| out_ready | input | 1 | Downstream can take a payload byte |
| hdr_ok | output | 1 | Signature matched |
| parse_err | output | 1 | Signature, tag, length or search-budget failure |
| payload_len | output | 32 | Latched payload section length |
| len_valid | output | 1 | payload_len is valid |
| done | output | 1 | Pulse when the whole payload has been forwarded |

## Verification
The bench aims at the search budget from both sides. With a skip of 91 content bytes the payload tag is read as header byte 99 and parsing must succeed. With 92 bytes the budget runs out, and a design that counted one byte too many or too few would either accept the image or fail it at the wrong byte count. It selects images other than the first and uses a payload that crosses several chunks. A de-interleaver with a wrong chunk or slot count would then forward foreign filler bytes or stall on them under backpressure. It checks the exact selected-byte position at which each error appears, so a design that skipped the oversize-length check would only fail later, at the budget limit, and be caught. It also checks a zero-length payload, which a design that waits for a first payload byte would never finish.

// File: rtl/ihw_pkg.sv
package ihw_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_MAGIC,
      ST_TAG,
      ST_LEN,
      ST_SKIP,
      ST_PAY,
      ST_DONE,
      ST_FAIL
   } walk_st_t;

   localparam int          MAGIC_LEN = 13;
   localparam logic [7:0]  TAG_FIRST = 8'h61;
   localparam logic [7:0]  TAG_LONG  = 8'h65;

   // Signature byte at position i of the selected image
   function automatic logic [7:0] magic_byte(input logic [3:0] i);
      logic [7:0] b;
      case (i)
         4'd1:                      b = 8'h09;
         4'd2, 4'd4, 4'd6, 4'd8:    b = 8'h0F;
         4'd3, 4'd5, 4'd7, 4'd9:    b = 8'hF0;
         4'd12:                     b = 8'h01;
         default:                   b = 8'h00;
      endcase
      return b;
   endfunction

endpackage

// File: rtl/ihw_chunk_sel.sv
module ihw_chunk_sel #(
   parameter int CHUNK_BYTES = 288,
   parameter int IMG_W       = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic             adv,
   input  logic [IMG_W-1:0] img_sel,
   input  logic [IMG_W-1:0] img_count,
   output logic             mine
);

   localparam int POS_W = $clog2(CHUNK_BYTES);

   logic [POS_W-1:0] pos;
   logic [IMG_W-1:0] slot;
   logic             pos_wrap;
   logic [IMG_W:0]   slot_inc;

   generate
      if ((CHUNK_BYTES & (CHUNK_BYTES - 1)) == 0) begin : g_pow2
         assign pos_wrap = &pos;
      end else begin : g_any
         assign pos_wrap = (pos == POS_W'(CHUNK_BYTES - 1));
      end
   endgenerate

   assign slot_inc = {1'b0, slot} + {{IMG_W{1'b0}}, 1'b1};
   assign mine     = (slot_inc == {1'b0, img_sel});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos  <= '0;
         slot <= '0;
      end else if (restart) begin
         pos  <= '0;
         slot <= '0;
      end else if (adv) begin
         if (pos_wrap) begin
            pos  <= '0;
            slot <= (slot_inc >= {1'b0, img_count}) ? '0 : slot_inc[IMG_W-1:0];
         end else begin
            pos <= pos + POS_W'(1);
         end
      end
   end

   // R2: the image slot stays inside the declared image count
   p_slot_range_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      (adv && img_count != '0) |-> (slot < img_count));

endmodule

// File: rtl/ihw_sect_walker.sv
module ihw_sect_walker
   import ihw_pkg::*;
#(
   parameter int SEARCH_LIMIT = 100,
   parameter int SHORT_MAX    = 255
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        restart,
   input  logic        take,
   input  logic [7:0]  din,
   input  logic        pay_last,
   output walk_st_t    st,
   output logic        want,
   output logic        hdr_ok,
   output logic        parse_err,
   output logic        done,
   output logic [31:0] pay_len
);

   localparam int HB_W = $clog2(SEARCH_LIMIT + 4);
   localparam logic [HB_W-1:0] HB_LIMIT = HB_W'(SEARCH_LIMIT);

   logic [HB_W-1:0] hb;
   logic [3:0]      idx;
   logic [31:0]     acc;
   logic [31:0]     nxt_len;
   logic [7:0]      skip_rem;
   logic            tag_long;
   logic            len_last;
   logic            hb_spent;
   logic            hb_next_spent;

   assign nxt_len       = {acc[23:0], din};
   assign len_last      = (idx == (tag_long ? 4'd3 : 4'd1));
   assign hb_spent      = (hb >= HB_LIMIT);
   assign hb_next_spent = ((hb + HB_W'(1)) >= HB_LIMIT);

   always_comb begin
      case (st)
         ST_MAGIC, ST_LEN, ST_SKIP, ST_PAY: want = 1'b1;
         ST_TAG:                            want = !hb_spent;
         default:                           want = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= ST_IDLE;
         idx       <= '0;
         hb        <= '0;
         acc       <= '0;
         skip_rem  <= '0;
         tag_long  <= 1'b0;
         hdr_ok    <= 1'b0;
         parse_err <= 1'b0;
         done      <= 1'b0;
         pay_len   <= '0;
      end else begin
         done <= 1'b0;
         if (restart) begin
            st        <= ST_MAGIC;
            idx       <= '0;
            hb        <= '0;
            acc       <= '0;
            skip_rem  <= '0;
            tag_long  <= 1'b0;
            hdr_ok    <= 1'b0;
            parse_err <= 1'b0;
            pay_len   <= '0;
         end else begin
            case (st)
               ST_MAGIC: if (take) begin
                  if (din != magic_byte(idx)) begin
                     st        <= ST_FAIL;
                     parse_err <= 1'b1;
                  end else if (idx == 4'(MAGIC_LEN - 1)) begin
                     st     <= ST_TAG;
                     hdr_ok <= 1'b1;
                     idx    <= '0;
                  end else begin
                     idx <= idx + 4'd1;
                  end
               end
               ST_TAG: begin
                  if (hb_spent) begin
                     st        <= ST_FAIL;
                     parse_err <= 1'b1;
                  end else if (take) begin
                     hb <= hb + HB_W'(1);
                     if (din < TAG_FIRST || din > TAG_LONG) begin
                        st        <= ST_FAIL;
                        parse_err <= 1'b1;
                     end else begin
                        tag_long <= (din == TAG_LONG);
                        idx      <= '0;
                        acc      <= '0;
                        st       <= ST_LEN;
                     end
                  end
               end
               ST_LEN: if (take) begin
                  acc <= nxt_len;
                  idx <= idx + 4'd1;
                  if (!tag_long) hb <= hb + HB_W'(1);
                  if (len_last) begin
                     idx <= '0;
                     if (tag_long) begin
                        pay_len <= nxt_len;
                        if (nxt_len == '0) begin
                           st   <= ST_DONE;
                           done <= 1'b1;
                        end else begin
                           st <= ST_PAY;
                        end
                     end else if (nxt_len > 32'(SHORT_MAX)) begin
                        st        <= ST_FAIL;
                        parse_err <= 1'b1;
                     end else if (nxt_len == '0 || hb_next_spent) begin
                        st <= ST_TAG;
                     end else begin
                        skip_rem <= nxt_len[7:0];
                        st       <= ST_SKIP;
                     end
                  end
               end
               ST_SKIP: if (take) begin
                  hb       <= hb + HB_W'(1);
                  skip_rem <= skip_rem - 8'd1;
                  if (skip_rem == 8'd1 || hb_next_spent) st <= ST_TAG;
               end
               ST_PAY: if (pay_last) begin
                  st   <= ST_DONE;
                  done <= 1'b1;
               end
               default: ;
            endcase
         end
      end
   end

   // R8: content is never skipped once the search budget is used up
   p_skip_budget_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_SKIP) |-> (hb < HB_LIMIT));

   // R4: sections are walked only behind a matched signature
   p_sections_need_magic_r4 : assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_TAG || st == ST_LEN || st == ST_SKIP || st == ST_PAY) |-> hdr_ok);

   // R3: an error holds until the next start
   p_err_sticky_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      (parse_err && !restart) |=> parse_err);

   // R6: the failed state is always flagged
   p_fail_flag_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_FAIL) |-> parse_err);

endmodule

// File: rtl/ihw_pay_counter.sv
module ihw_pay_counter #(
   parameter int LEN_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic             beat,
   input  logic [LEN_W-1:0] pay_len,
   output logic             last
);

   logic [LEN_W-1:0] cnt;

   assign last = beat && ((cnt + LEN_W'(1)) == pay_len);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt <= '0;
      else if (restart) cnt <= '0;
      else if (beat)    cnt <= cnt + LEN_W'(1);
   end

   // R9: no byte is forwarded past the latched length
   p_beat_in_len_r9 : assert property (@(posedge clk) disable iff (!rst_n)
      beat |-> (cnt < pay_len));

endmodule

// File: rtl/ilv_bitstream_parser.sv
module ilv_bitstream_parser
   import ihw_pkg::*;
#(
   parameter int CHUNK_BYTES  = 288,
   parameter int IMG_W        = 4,
   parameter int SEARCH_LIMIT = 100,
   parameter int SHORT_MAX    = 255
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [IMG_W-1:0] img_sel,
   input  logic [IMG_W-1:0] img_count,
   input  logic             in_valid,
   input  logic [7:0]       in_data,
   output logic             in_ready,
   output logic             out_valid,
   output logic [7:0]       out_data,
   input  logic             out_ready,
   output logic             hdr_ok,
   output logic             parse_err,
   output logic [31:0]      payload_len,
   output logic             len_valid,
   output logic             done
);

   localparam int LEN_W = 32;

   generate
      if (CHUNK_BYTES < 2)                  begin : g_bad_chunk  $error("CHUNK_BYTES must be at least 2"); end
      if (IMG_W < 1)                        begin : g_bad_img    $error("IMG_W must be at least 1"); end
      if (SEARCH_LIMIT < 4)                 begin : g_bad_limit  $error("SEARCH_LIMIT must be at least 4"); end
      if (SHORT_MAX < 1 || SHORT_MAX > 255) begin : g_bad_short  $error("SHORT_MAX must lie in 1..255"); end
   endgenerate

   walk_st_t st;
   logic     mine;
   logic     want;
   logic     in_pay;
   logic     take;
   logic     sel_take;
   logic     beat;
   logic     pay_last;

   assign in_pay    = (st == ST_PAY);
   assign in_ready  = !start && want && (!(mine && in_pay) || out_ready);
   assign take      = in_valid && in_ready;
   assign sel_take  = take && mine;
   assign beat      = sel_take && in_pay;
   assign out_valid = !start && in_valid && mine && in_pay;
   assign out_data  = in_data;
   assign len_valid = in_pay || (st == ST_DONE);

   ihw_chunk_sel #(
      .CHUNK_BYTES (CHUNK_BYTES),
      .IMG_W       (IMG_W)
   ) u_chunk (
      .clk       (clk),
      .rst_n     (rst_n),
      .restart   (start),
      .adv       (take),
      .img_sel   (img_sel),
      .img_count (img_count),
      .mine      (mine)
   );

   ihw_sect_walker #(
      .SEARCH_LIMIT (SEARCH_LIMIT),
      .SHORT_MAX    (SHORT_MAX)
   ) u_walk (
      .clk       (clk),
      .rst_n     (rst_n),
      .restart   (start),
      .take      (sel_take),
      .din       (in_data),
      .pay_last  (pay_last),
      .st        (st),
      .want      (want),
      .hdr_ok    (hdr_ok),
      .parse_err (parse_err),
      .done      (done),
      .pay_len   (payload_len)
   );

   ihw_pay_counter #(
      .LEN_W (LEN_W)
   ) u_pay (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (start),
      .beat    (beat),
      .pay_len (payload_len),
      .last    (pay_last)
   );

   // R9: a held payload byte blocks the input
   p_backpressure_r9 : assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |-> !in_ready);

   // R10: done lasts a single cycle
   p_done_pulse_r10 : assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R10: completion and error are exclusive
   p_done_no_err_r10 : assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !parse_err);

   // R10: nothing is accepted once finished
   p_quiet_after_done_r10 : assert property (@(posedge clk) disable iff (!rst_n)
      (done && !start) |-> !in_ready);

endmodule

// File: tb/ilv_bitstream_parser_tb_top.sv
module ilv_bitstream_parser_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int CHUNK      = 288;
   localparam int NVEC       = 9;

   // {kind, sel, count, backpressure, skip, plen, exp_err, exp_hdr}
   // kind: 0 good, 1 bad signature, 2 bad tag, 3 oversize length
   localparam logic [39:0] VECS [0:NVEC-1] = '{
      {4'd0, 4'd1, 4'd1, 4'd0, 8'd4,  14'd20,  1'b0, 1'b1},
      {4'd0, 4'd2, 4'd3, 4'd1, 8'd10, 14'd600, 1'b0, 1'b1},
      {4'd0, 4'd3, 4'd3, 4'd2, 8'd91, 14'd5,   1'b0, 1'b1},
      {4'd0, 4'd1, 4'd2, 4'd0, 8'd92, 14'd5,   1'b1, 1'b1},
      {4'd1, 4'd2, 4'd2, 4'd0, 8'd4,  14'd8,   1'b1, 1'b0},
      {4'd2, 4'd1, 4'd1, 4'd1, 8'd0,  14'd8,   1'b1, 1'b1},
      {4'd3, 4'd4, 4'd4, 4'd0, 8'd3,  14'd8,   1'b1, 1'b1},
      {4'd0, 4'd1, 4'd2, 4'd0, 8'd0,  14'd0,   1'b0, 1'b1},
      {4'd0, 4'd4, 4'd4, 4'd1, 8'd20, 14'd300, 1'b0, 1'b1}
   };

   localparam logic [7:0] SIG [0:12] = '{
      8'h00, 8'h09, 8'h0F, 8'hF0, 8'h0F, 8'hF0, 8'h0F,
      8'hF0, 8'h0F, 8'hF0, 8'h00, 8'h00, 8'h01
   };

   logic        clk;
   logic        rst_n;
   logic        start;
   logic [3:0]  img_sel;
   logic [3:0]  img_count;
   logic        in_valid;
   logic [7:0]  in_data;
   logic        in_ready;
   logic        out_valid;
   logic [7:0]  out_data;
   logic        out_ready;
   logic        hdr_ok;
   logic        parse_err;
   logic [31:0] payload_len;
   logic        len_valid;
   logic        done;

   int n_chk = 0;
   int n_bad = 0;

   logic [7:0] img [0:1023];
   int img_len = 0;
   int cur_sel = 1;
   int cur_cnt = 1;

   ilv_bitstream_parser dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (start),
      .img_sel     (img_sel),
      .img_count   (img_count),
      .in_valid    (in_valid),
      .in_data     (in_data),
      .in_ready    (in_ready),
      .out_valid   (out_valid),
      .out_data    (out_data),
      .out_ready   (out_ready),
      .hdr_ok      (hdr_ok),
      .parse_err   (parse_err),
      .payload_len (payload_len),
      .len_valid   (len_valid),
      .done        (done)
   );

   initial clk = 1'b0;
   always #(CLK_PERIOD / 2) clk = ~clk;

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL R10 watchdog expired: actual=1 expected=0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   function automatic bit is_mine(int g);
      int chunk = g / CHUNK;
      return ((chunk % cur_cnt) == cur_sel - 1);
   endfunction

   function automatic logic [7:0] stream_byte(int g);
      int chunk = g / CHUNK;
      int idx;
      if (is_mine(g)) begin
         idx = (chunk / cur_cnt) * CHUNK + (g % CHUNK);
         return (idx < img_len) ? img[idx] : 8'h00;
      end
      return 8'hC3 ^ 8'(g);
   endfunction

   function automatic logic [7:0] pay_byte(int i, int sel);
      return 8'(i * 13 + sel * 5 + 1);
   endfunction

   task automatic build(input int kind, input int sk, input int plen, input int sel);
      int k = 0;
      for (int i = 0; i < 13; i++) begin img[k] = SIG[i]; k++; end
      img[k] = 8'h61; k++; img[k] = 8'h00; k++; img[k] = 8'(sk); k++;
      for (int i = 0; i < sk; i++) begin img[k] = 8'h5A ^ 8'(i); k++; end
      img[k] = (kind == 2) ? 8'h66 : 8'h64; k++;
      if (kind == 3) begin img[k] = 8'h01; k++; img[k] = 8'h00; k++; end
      else begin img[k] = 8'h00; k++; img[k] = 8'h02; k++; end
      img[k] = 8'h11; k++; img[k] = 8'h22; k++;
      img[k] = 8'h65; k++;
      img[k] = 8'(plen >> 24); k++; img[k] = 8'(plen >> 16); k++;
      img[k] = 8'(plen >> 8);  k++; img[k] = 8'(plen);       k++;
      for (int i = 0; i < plen; i++) begin img[k] = pay_byte(i, sel); k++; end
      img_len = k;
      if (kind == 1) img[4] = img[4] ^ 8'h01;
   endtask

   task automatic pulse_start();
      @(negedge clk);
      in_valid = 1'b0;
      start    = 1'b1;
      @(negedge clk);
      start = 1'b0;
      #1;
   endtask

   task automatic run_vec(input logic [39:0] v, input int abort_after);
      int kind  = int'(v[39:36]);
      int sel   = int'(v[35:32]);
      int cnt   = int'(v[31:28]);
      int bp    = int'(v[27:24]);
      int sk    = int'(v[23:16]);
      int plen  = int'(v[15:2]);
      bit e_err = v[1];
      bit e_hdr = v[0];
      int g = 0, pidx = 0, done_cnt = 0, err_pos = -1, sel_taken = 0;
      int stall_viol = 0, foreign_out = 0, pay_bad = 0, cyc = 0, tail = -1;
      bit last_rdy = 1'b0;
      int exp_pos;
      string req;

      cur_sel = sel; cur_cnt = cnt;
      img_sel = 4'(sel); img_count = 4'(cnt);
      build(kind, sk, plen, sel);
      pulse_start();
      // R11: start clears everything
      chk(!hdr_ok && !parse_err && !len_valid && !done, "R11", "flags after start",
          {hdr_ok, parse_err, len_valid, done}, 0);

      while (1) begin
         @(negedge clk);
         in_valid  = 1'b1;
         in_data   = stream_byte(g);
         out_ready = (bp == 0) ? 1'b1 : (bp == 1) ? (cyc % 2 == 0) : (cyc % 3 == 0);
         #1;
         if (done) done_cnt++;
         if (parse_err && err_pos < 0) err_pos = sel_taken;
         if (out_valid) begin
            if (!is_mine(g)) foreign_out++;
            if (out_ready) begin
               if (pidx >= plen || out_data != pay_byte(pidx, sel)) pay_bad++;
               pidx++;
            end
         end
         if (len_valid && done_cnt == 0 && !is_mine(g) && !in_ready) stall_viol++;
         last_rdy = in_ready;
         if (in_valid && in_ready) begin
            if (is_mine(g)) sel_taken++;
            g++;
         end
         cyc++;
         if (tail < 0 && (done_cnt > 0 || parse_err)) tail = 4;
         else if (tail > 0) tail--;
         if (tail == 0) break;
         if (abort_after > 0 && cyc >= abort_after) break;
         if (cyc > 20000) break;
      end
      in_valid = 1'b0;

      if (abort_after > 0) begin
         chk(hdr_ok == 1'b1, "R4", "signature seen before abort", hdr_ok, 1);
         return;
      end

      case (kind)
         1: req = "R3";
         2: req = "R6";
         3: req = "R7";
         default: req = e_err ? "R8" : "R5";
      endcase
      chk(parse_err == e_err, req, "parse_err", parse_err, e_err);
      chk(hdr_ok == e_hdr, "R4", "hdr_ok", hdr_ok, e_hdr);
      if (e_err) begin
         case (kind)
            1: exp_pos = 5;
            2: exp_pos = 13 + 3 + sk + 1;
            3: exp_pos = 13 + 3 + sk + 3;
            default: exp_pos = 13 + 100;
         endcase
         chk(err_pos == exp_pos, req, "selected bytes consumed at error", err_pos, exp_pos);
         chk(done_cnt == 0, "R10", "no done with error", done_cnt, 0);
         chk(last_rdy == 1'b0, req, "input halted after error", last_rdy, 0);
      end else begin
         chk(payload_len == 32'(plen), "R5", "payload_len", payload_len, plen);
         chk(len_valid == 1'b1, "R5", "len_valid", len_valid, 1);
         chk(pidx == plen && pay_bad == 0, "R9", "payload bytes forwarded in order", pidx, plen);
         chk(done_cnt == 1, "R10", "single done pulse", done_cnt, 1);
         chk(last_rdy == 1'b0, "R10", "input halted after done", last_rdy, 0);
         chk(foreign_out == 0, "R2", "foreign bytes on output", foreign_out, 0);
         chk(stall_viol == 0, "R2", "foreign bytes stalled", stall_viol, 0);
      end
   endtask

   initial begin
      rst_n     = 1'b0;
      start     = 1'b0;
      img_sel   = 4'd1;
      img_count = 4'd1;
      in_valid  = 1'b0;
      in_data   = 8'h00;
      out_ready = 1'b1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      in_valid = 1'b1;
      in_data  = 8'h00;
      @(negedge clk);
      #1;
      // R1: idle after reset, nothing accepted
      chk(in_ready == 1'b0, "R1", "in_ready idle", in_ready, 0);
      chk(out_valid == 1'b0, "R1", "out_valid idle", out_valid, 0);
      chk(!hdr_ok && !parse_err && !len_valid && !done, "R1", "flags idle",
          {hdr_ok, parse_err, len_valid, done}, 0);
      @(negedge clk);
      start = 1'b1;
      #1;
      chk(in_ready == 1'b0, "R1", "no accept in start cycle", in_ready, 0);
      @(negedge clk);
      start = 1'b0;
      in_valid = 1'b0;

      for (int i = 0; i < NVEC; i++) run_vec(VECS[i], 0);

      // R11: restart in the middle of a parse, then a full clean parse
      run_vec(VECS[0], 30);
      run_vec(VECS[0], 0);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule